// File: doc/BRIEF.md
# Binary Field Inverter (Itoh-Tsujii, Quad Power Block)

This block computes the multiplicative inverse of a nonzero element of GF(2^M) in polynomial basis. It raises the operand to the power 2^M - 2 by building a^(2^k - 1) along an addition chain for M - 1. Each chain step raises the running value to a power of two and then multiplies by either the running value (a doubling step) or the original operand (an increment step). One final squaring turns a^(2^(M-1) - 1) into the inverse.

The raising is done by a power block made of CASC identical x^4 circuits in cascade, plus a single squaring tap. A selector chooses how many quad stages feed the output, or the squaring tap, so one cycle can apply up to 2·CASC squarings. A bit-parallel multiplier handles the products. In any cycle only one of the two units does useful work, and the multiplier result is held in the register `mout`. The field size, the reduction polynomial and the cascade depth are parameters. The chain is derived from M - 1 when the design is elaborated.

A user places the operand on `a_in` and pulses `start`. `done` is then high for one cycle with the result on `inv_out`. The result stays there until the next result replaces it.

Top module: `itoh_inv`

## Requirements
- R1: For every nonzero `a_in`, `inv_out` times `a_in` equals 1 in GF(2^M). The field is reduced by x^M + POLY, where bit i of POLY is the coefficient of x^i for i < M.
- R2: `done` is high for exactly one cycle per computation, and `inv_out` carries the result in that cycle.
- R3: A `start` that arrives while a computation is running is ignored. The running result and its latency do not change.
- R4: `mout` changes only in a multiply cycle or when a start is accepted. A power-block cycle never alters it.
- R5: `done` rises L clock edges after the edge that accepts `start`, counting that edge. L = 2 + Σ (P(e) + 1) over the chain steps. The chain comes from the binary digits of M-1 below its top one: each digit gives a doubling step, followed by an increment step when the digit is 1. Here e is the current chain index k for a doubling step and 1 for an increment step, and P(e) = ceil(floor(e/2)/CASC) + (e mod 2). For M=4, CASC=2 this gives L = 6. For M=15, CASC=3 it gives L = 14.
- R6: While reset is asserted and directly after it, `done` is 0 and `inv_out` is 0.
- R7: `inv_out` holds its value in every cycle where `done` is low.
- R8: A `start` sampled in the same cycle as `done` begins the next computation at once, with the latency of R5.
- R9: The block supports M=4 with x^4+x+1 (POLY=4'b0011) and M=15 with x^15+x+1 (POLY=15'h0003).
- R10: A power-block cycle selects between 0 and CASC quad stages, and it is only entered with squarings still owed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an inversion of `a_in` (sampled when idle) |
| a_in | input | M | Operand, polynomial basis, must be nonzero |
| inv_out | output | M | Inverse of the last operand |
| done | output | 1 | One-cycle pulse when `inv_out` is fresh |

## Verification
Two functions can fall in the same cycle: the completion pulse of one inversion and the acceptance of the next `start`. The sweep over all fifteen nonzero elements of GF(2^4) provokes this on purpose. It raises `start` with the next operand in the very cycle `done` is seen. Each result is then judged by both its field product with the operand and its edge count against the closed-form latency, so a lost or delayed start shows as a latency or product error. A start injected mid-computation is judged the same way, since it must leave the result and its timing untouched.

// File: rtl/itoh_inv.sv
module itoh_inv #(
  parameter int M = 4,
  parameter logic [M-1:0] POLY = 4'b0011,
  parameter int CASC = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a_in,
  output logic [M-1:0] inv_out,
  output logic         done
);

  localparam int N      = M - 1;
  localparam int TOP    = $clog2(N + 1) - 1;
  localparam int MAXOPS = 2 * $clog2(M + 1) + 2;
  localparam int KW     = $clog2(2 * M + 1) + 1;
  localparam int STW    = $clog2(MAXOPS + 1);
  localparam int SW     = $clog2(CASC + 1);

  function automatic logic [M-1:0] xpow(input int e);
    logic [M-1:0] r;
    r = M'(1);
    for (int i = 0; i < e; i++) r = r[M-1] ? ((r << 1) ^ POLY) : (r << 1);
    return r;
  endfunction

  function automatic int chain_len();
    int len;
    len = 0;
    for (int j = TOP - 1; j >= 0; j--) begin
      len++;
      if (((N >> j) & 1) == 1) len++;
    end
    return len;
  endfunction

  function automatic logic [MAXOPS-1:0] chain_ops();
    logic [MAXOPS-1:0] ops;
    int idx;
    ops = '0;
    idx = 0;
    for (int j = TOP - 1; j >= 0; j--) begin
      idx++;
      if (((N >> j) & 1) == 1) begin
        ops[idx] = 1'b1;
        idx++;
      end
    end
    return ops;
  endfunction

  localparam int LEN = chain_len();
  localparam logic [MAXOPS-1:0] OPS = chain_ops();

  typedef enum logic [1:0] {S_IDLE, S_POW, S_MUL} state_t;
  state_t state;

  logic [M-1:0]   a_reg, mout, pw;
  logic [KW-1:0]  rem, k;
  logic [STW-1:0] step;
  logic           last;

  logic [M-1:0] tcol [M];
  logic [M-1:0] qcol [M];
  for (genvar i = 0; i < M; i++) begin : g_cols
    assign tcol[i] = xpow(2 * i);
    assign qcol[i] = xpow(4 * i);
  end

  logic [M-1:0] sq_out;
  logic [M-1:0] taps [CASC];
  always_comb begin
    sq_out = '0;
    for (int i = 0; i < M; i++) if (pw[i]) sq_out ^= tcol[i];
  end

  always_comb begin
    logic [M-1:0] v, nv;
    v = pw;
    for (int c = 0; c < CASC; c++) begin
      nv = '0;
      for (int i = 0; i < M; i++) if (v[i]) nv ^= qcol[i];
      v = nv;
      taps[c] = v;
    end
  end

  logic [KW-1:0] half, quads, rem_n;
  logic [SW-1:0] q_sel;
  always_comb begin
    half  = rem >> 1;
    quads = (half > KW'(CASC)) ? KW'(CASC) : half;
    if (rem >= KW'(2)) begin
      q_sel = SW'(quads);
      rem_n = rem - (quads << 1);
    end else begin
      q_sel = '0;
      rem_n = rem - KW'(1);
    end
  end

  logic [M-1:0] pow_out;
  assign pow_out = (q_sel == '0) ? sq_out : taps[q_sel - SW'(1)];

  logic         op_cur, op_nxt;
  logic [M-1:0] mul_b, prod;
  logic [KW-1:0] k_new;
  assign op_cur = OPS[step];
  assign op_nxt = (int'(step) + 1 < MAXOPS) ? OPS[step + STW'(1)] : 1'b0;
  assign mul_b  = op_cur ? a_reg : mout;
  assign k_new  = op_cur ? k + KW'(1) : k << 1;

  always_comb begin
    prod = '0;
    for (int i = M - 1; i >= 0; i--) begin
      prod = prod[M-1] ? ((prod << 1) ^ POLY) : (prod << 1);
      if (mul_b[i]) prod ^= pw;
    end
  end

  logic pow_en, mul_en;
  assign pow_en = (state == S_POW);
  assign mul_en = (state == S_MUL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      a_reg   <= '0;
      mout    <= '0;
      pw      <= '0;
      rem     <= '0;
      k       <= '0;
      step    <= '0;
      last    <= 1'b0;
      inv_out <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          a_reg <= a_in;
          mout  <= a_in;
          pw    <= a_in;
          rem   <= KW'(1);
          k     <= KW'(1);
          step  <= '0;
          last  <= (LEN == 0);
          state <= S_POW;
        end
        S_POW: begin
          pw  <= pow_out;
          rem <= rem_n;
          if (rem_n == '0) begin
            if (last) begin
              inv_out <= pow_out;
              done    <= 1'b1;
              state   <= S_IDLE;
            end else begin
              state <= S_MUL;
            end
          end
        end
        S_MUL: begin
          mout  <= prod;
          pw    <= prod;
          k     <= k_new;
          step  <= step + STW'(1);
          state <= S_POW;
          if (step == STW'(LEN - 1)) begin
            last <= 1'b1;
            rem  <= KW'(1);
          end else begin
            rem <= op_nxt ? KW'(1) : k_new;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_busy_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE) |=> $stable(a_reg));

  p_mout_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pow_en || (state == S_IDLE && !start)) |=> $stable(mout));

  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(inv_out));

  p_sel_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pow_en |-> (rem != '0) && (q_sel <= SW'(CASC)));

  p_mul_follows_pow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mul_en |=> pow_en);

endmodule

// File: tb/itoh_inv_tb.sv
module itoh_inv_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(PERIOD / 2) clk = ~clk;

  logic        st4 = 1'b0, st15 = 1'b0;
  logic [3:0]  a4 = '0, inv4;
  logic [14:0] a15 = '0, inv15;
  logic        done4, done15;

  int n_chk = 0;
  int n_bad = 0;

  itoh_inv #(.M(4), .POLY(4'b0011), .CASC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(st4), .a_in(a4),
    .inv_out(inv4), .done(done4));

  itoh_inv #(.M(15), .POLY(15'h0003), .CASC(3)) u_dut_big (
    .clk(clk), .rst_n(rst_n), .start(st15), .a_in(a15),
    .inv_out(inv15), .done(done15));

  function automatic int gmul(input int x, input int y, input int m, input int poly);
    int acc;
    int msk;
    acc = 0;
    msk = (1 << m) - 1;
    for (int i = m - 1; i >= 0; i--) begin
      acc = ((acc >> (m - 1)) & 1) ? (((acc << 1) & msk) ^ poly) : ((acc << 1) & msk);
      if ((y >> i) & 1) acc ^= x;
    end
    return acc;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Call at a negedge; returns at the negedge where done is seen.
  task automatic go(input bit big, input int val, input int lat, input int inj, input string tag);
    int cnt;
    int res;
    bit dn;
    if (big) begin a15 = 15'(val); st15 = 1'b1; end
    else     begin a4  = 4'(val);  st4  = 1'b1; end
    cnt = 0;
    do begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      st4 = 1'b0;
      st15 = 1'b0;
      if (!big && inj != 0 && cnt == inj) begin a4 = 4'd9; st4 = 1'b1; end
      dn = big ? done15 : done4;
    end while (!dn && cnt < 300);
    res = big ? int'(inv15) : int'(inv4);
    chk(cnt == lat, {"R5 latency ", tag}, cnt, lat);
    chk(gmul(val, res, big ? 15 : 4, big ? 3 : 3) == 1, {"R1 product ", tag},
        gmul(val, res, big ? 15 : 4, 3), 1);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int hold;
    repeat (3) @(negedge clk);
    chk(done4 == 1'b0 && done15 == 1'b0, "R6 done in reset", int'(done4), 0);
    chk(inv4 == '0 && inv15 == '0, "R6 out in reset", int'(inv4), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done4 == 1'b0, "R6 done after reset", int'(done4), 0);
    chk(inv4 == '0, "R6 out after reset", int'(inv4), 0);

    // R8 R9: back-to-back sweep, next start raised in the done cycle
    for (int v = 1; v < 16; v++) go(1'b0, v, 6, 0, "R8 R9 gf16 sweep");

    @(negedge clk);
    chk(done4 == 1'b0, "R2 single pulse", int'(done4), 0);

    // R3: start injected mid-run must not change result or timing
    @(negedge clk);
    go(1'b0, 5, 6, 2, "R3 busy start");
    hold = int'(inv4);
    chk(gmul(5, hold, 4, 3) == 1, "R3 kept operand", gmul(5, hold, 4, 3), 1);

    // R7: output holds while idle
    repeat (5) @(negedge clk);
    chk(int'(inv4) == hold, "R7 hold", int'(inv4), hold);
    chk(done4 == 1'b0, "R2 no extra done", int'(done4), 0);

    // R9 larger field, random nonzero operands
    @(negedge clk);
    go(1'b1, 1, 14, 0, "R9 gf32k one");
    chk(int'(inv15) == 1, "R1 inverse of one", int'(inv15), 1);
    go(1'b1, 15'h7fff, 14, 0, "R9 gf32k all ones");
    for (int t = 0; t < 40; t++) begin
      int r;
      r = int'($urandom_range(32767, 1));
      go(1'b1, r, 14, 0, "R9 gf32k random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule